// File: doc/BRIEF.md
# Transceiver Configuration Serial Master

This block is a hardware engine that programs an external infrared transceiver module over a two-wire clock/data link, in place of software that toggles the pins one at a time. The module answers on two return lines: a read-valid line and a receive-data line. A host hands over one command at a time with a valid/ready handshake. The command carries an operation code, a device address, a 2-bit register index and a write byte. The engine then produces the whole waveform by itself.

There are three operations. A write sends a command byte, a data byte and a short tail of clocks. A read sends a command byte and then clocks the link while it waits, for a bounded number of pulses, for the module to signal that it is ready. It then clocks in the reply byte and ends with a fixed tail. A reset request sends a long burst of clock pulses with the data line held low. When a read finishes, the engine reports the byte and a timeout flag with a one-cycle strobe.

Each clock phase lasts a number of system-clock cycles set by a parameter. Each pulse is followed by a one-cycle gap with the clock low. The engine samples its inputs in that gap, so the return lines are read just after each falling edge. The return lines are taken to be synchronous to the system clock.

Top module: `xcvr_cfg_master`

## Requirements
- R1: The command byte is the device address OR the register index shifted left by one OR a direction bit in bit 0. The direction bit is 1 for a write and 0 for a read. The operation code is 00 for write, 01 for read, and 1x for reset.
- R2: Every byte goes out least-significant bit first. The data line changes only while the clock is low, and it has been stable for at least PHASE_CYCLES system cycles when the clock rises.
- R3: A write gives 18 clock pulses: 8 command bits, 8 data bits, then 2 pulses with data low. It ends with the clock low.
- R4: After a read command byte, the engine gives wait pulses with data high, at most WAIT_LIMIT of them. It samples the read-valid line after each pulse falls and stops waiting at the first low sample.
- R5: Once read-valid has been seen low, the engine clocks in 8 bits, least-significant bit first. It samples the receive line after each falling clock edge.
- R6: If read-valid stays high through all WAIT_LIMIT wait pulses, the engine gives only 2 further pulses with data high. It then reports data 0 with the timeout flag set.
- R7: Every read ends with 1 pulse with data high, then 3 pulses with data low. A read with a response after k wait pulses therefore has 20+k pulses, and a timed-out read has 24 pulses.
- R8: A reset request gives RESET_PULSES (30) pulses with data low and ends with the clock low.
- R9: Every clock high phase lasts exactly PHASE_CYCLES system cycles.
- R10: cmdReady is low from the cycle after acceptance until the transfer ends. A cmdValid presented while cmdReady is low has no effect on the waveform.
- R11: rspDone is a one-cycle pulse that comes at the end of each read, with rspData and rspTimeout valid. It never comes after a write or a reset.
- R12: During and right after reset, cfgClk and cfgData are low, cmdReady is high and rspDone is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset |
| cmdValid | input | 1 | Command offered |
| cmdReady | output | 1 | Engine idle, command accepted on valid |
| cmdOp | input | 2 | 00 write, 01 read, 1x reset |
| cmdAddr | input | 8 | Device address, bits 0..2 normally zero |
| cmdIndex | input | 2 | Register index |
| cmdWdata | input | 8 | Byte to write |
| rspDone | output | 1 | One-cycle read completion strobe |
| rspData | output | 8 | Byte read back (0 on timeout) |
| rspTimeout | output | 1 | Module never signalled ready |
| cfgClk | output | 1 | Serial clock to the module |
| cfgData | output | 1 | Serial data to the module |
| cfgRdValid | input | 1 | Module read-valid return line, low when ready |
| cfgRxData | input | 1 | Module read data return line |

## Verification
The bench builds the engine with PHASE_CYCLES set to 3 and keeps WAIT_LIMIT at 10 and RESET_PULSES at 30. A short phase keeps each transfer near a hundred cycles, so several dozen transfers of all three kinds fit in one run. With the full ten-pulse wait window, the bench can place the module's answer on the first wait pulse, on the last one, or never. These are the two edges of the wait loop and the timeout path. A behavioural module model in the bench answers on the return lines only after falling clock edges. This checks that sampling happens in the gap after each pulse and not before it.

// File: rtl/xcvr_cfg_pkg.sv
package xcvr_cfg_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    PH_IDLE, PH_LAUNCH, PH_LOW, PH_HIGH, PH_GAP
  } phaseE;

  typedef enum logic [3:0] {
    SEG_CMD, SEG_WDATA, SEG_WTAIL, SEG_WAIT, SEG_RDATA,
    SEG_SKIP, SEG_RTAIL1, SEG_RTAIL3, SEG_RESET
  } segE;

  typedef struct packed {
    logic loadTx;
    logic shiftOut;
    logic driveOne;
    logic driveZero;
    logic clkRise;
    logic clkFall;
    logic timerGo;
    logic captureRx;
    logic clearRx;
  } dpStrobeT;
endpackage

// File: rtl/xcvr_cfg_dp.sv
module xcvr_cfg_dp
  import xcvr_cfg_pkg::*;
#(
  parameter int PHASE_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobeT          strobe,
  input  logic [BYTE_W-1:0] cmdByte,
  input  logic [BYTE_W-1:0] wrByte,
  input  logic              cfgRxData,
  output logic              phaseDone,
  output logic              cfgClk,
  output logic              cfgData,
  output logic [BYTE_W-1:0] rxByte
);
  localparam int TMR_W = (PHASE_CYCLES > 1) ? $clog2(PHASE_CYCLES) : 1;
  localparam logic [TMR_W-1:0] TMR_LOAD = TMR_W'(PHASE_CYCLES - 1);

  logic [TMR_W-1:0]    phaseTmr;
  logic [2*BYTE_W-1:0] txShift;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 phaseTmr <= '0;
    else if (strobe.timerGo)   phaseTmr <= TMR_LOAD;
    else if (phaseTmr != '0)   phaseTmr <= phaseTmr - 1'b1;
  end
  assign phaseDone = (phaseTmr == '0);

  // command byte and data byte leave as one 16-bit LSB-first stream
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 txShift <= '0;
    else if (strobe.loadTx)    txShift <= {wrByte, cmdByte};
    else if (strobe.shiftOut)  txShift <= txShift >> 1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 cfgData <= 1'b0;
    else if (strobe.shiftOut)  cfgData <= txShift[0];
    else if (strobe.driveOne)  cfgData <= 1'b1;
    else if (strobe.driveZero) cfgData <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 cfgClk <= 1'b0;
    else if (strobe.clkRise)   cfgClk <= 1'b1;
    else if (strobe.clkFall)   cfgClk <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  rxByte <= '0;
    else if (strobe.clearRx)    rxByte <= '0;
    else if (strobe.captureRx)  rxByte <= {cfgRxData, rxByte[BYTE_W-1:1]};
  end

  // data must not move while the serial clock is high or as it rises (R2)
  assert_data_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    cfgClk |-> $stable(cfgData));

  logic [TMR_W:0] hiRun;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       hiRun <= '0;
    else if (cfgClk) hiRun <= hiRun + 1'b1;
    else             hiRun <= '0;
  end
  assert_high_width_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cfgClk) |-> hiRun == (TMR_W+1)'(PHASE_CYCLES));
endmodule

// File: rtl/xcvr_cfg_ctrl.sv
module xcvr_cfg_ctrl
  import xcvr_cfg_pkg::*;
#(
  parameter int WAIT_LIMIT   = 10,
  parameter int RESET_PULSES = 30
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     cmdValid,
  input  logic [1:0] cmdOp,
  input  logic     phaseDone,
  input  logic     cfgRdValid,
  output dpStrobeT strobe,
  output logic     cmdReady,
  output logic     rspDone,
  output logic     rspTimeout
);
  localparam int MAX_A   = (RESET_PULSES > WAIT_LIMIT) ? RESET_PULSES : WAIT_LIMIT;
  localparam int MAX_CNT = (MAX_A > BYTE_W) ? MAX_A : BYTE_W;
  localparam int CNT_W   = $clog2(MAX_CNT + 1);
  localparam logic [CNT_W-1:0] BYTE_C = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] WAIT_C = CNT_W'(WAIT_LIMIT);
  localparam logic [CNT_W-1:0] RST_C  = CNT_W'(RESET_PULSES);
  localparam logic [CNT_W-1:0] TWO_C  = CNT_W'(2);
  localparam logic [CNT_W-1:0] THREE_C = CNT_W'(3);

  phaseE phase, phaseN;
  segE   seg, segN, nxt, slotSeg;
  logic [CNT_W-1:0] bitCnt, cntN, cntInc;
  logic isRead, isReadN, timeoutN, doneN, finish, startSlot;

  always_comb begin
    strobe    = '0;
    phaseN    = phase;
    segN      = seg;
    cntN      = bitCnt;
    isReadN   = isRead;
    timeoutN  = rspTimeout;
    doneN     = 1'b0;
    startSlot = 1'b0;
    slotSeg   = seg;
    nxt       = seg;
    finish    = 1'b0;
    cntInc    = bitCnt + 1'b1;
    unique case (phase)
      PH_IDLE: if (cmdValid) begin
        strobe.loadTx  = 1'b1;
        strobe.clearRx = 1'b1;
        isReadN  = (cmdOp == 2'b01);
        timeoutN = 1'b0;
        segN     = cmdOp[1] ? SEG_RESET : SEG_CMD;
        cntN     = '0;
        phaseN   = PH_LAUNCH;
      end
      PH_LAUNCH: startSlot = 1'b1;
      PH_LOW: if (phaseDone) begin
        strobe.clkRise = 1'b1;
        strobe.timerGo = 1'b1;
        phaseN = PH_HIGH;
      end
      PH_HIGH: if (phaseDone) begin
        strobe.clkFall = 1'b1;
        phaseN = PH_GAP;
      end
      PH_GAP: begin
        unique case (seg)
          SEG_CMD:    if (cntInc == BYTE_C) nxt = isRead ? SEG_WAIT : SEG_WDATA;
          SEG_WDATA:  if (cntInc == BYTE_C) nxt = SEG_WTAIL;
          SEG_WTAIL:  if (cntInc == TWO_C) finish = 1'b1;
          SEG_WAIT: begin
            if (!cfgRdValid) nxt = SEG_RDATA;
            else if (cntInc == WAIT_C) begin
              nxt      = SEG_SKIP;
              timeoutN = 1'b1;
            end
          end
          SEG_RDATA: begin
            strobe.captureRx = 1'b1;
            if (cntInc == BYTE_C) nxt = SEG_RTAIL1;
          end
          SEG_SKIP:   if (cntInc == TWO_C) nxt = SEG_RTAIL1;
          SEG_RTAIL1: nxt = SEG_RTAIL3;
          SEG_RTAIL3: if (cntInc == THREE_C) begin
            finish = 1'b1;
            doneN  = 1'b1;
          end
          SEG_RESET:  if (cntInc == RST_C) finish = 1'b1;
          default:    finish = 1'b1;
        endcase
        if (finish) begin
          phaseN = PH_IDLE;
        end else begin
          startSlot = 1'b1;
          slotSeg   = nxt;
          segN      = nxt;
          cntN      = (nxt == seg) ? cntInc : '0;
        end
      end
      default: phaseN = PH_IDLE;
    endcase
    if (startSlot) begin
      phaseN = PH_LOW;
      strobe.timerGo = 1'b1;
      unique case (slotSeg)
        SEG_CMD, SEG_WDATA:               strobe.shiftOut  = 1'b1;
        SEG_WTAIL, SEG_RTAIL3, SEG_RESET: strobe.driveZero = 1'b1;
        default:                          strobe.driveOne  = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase      <= PH_IDLE;
      seg        <= SEG_CMD;
      bitCnt     <= '0;
      isRead     <= 1'b0;
      rspTimeout <= 1'b0;
      rspDone    <= 1'b0;
    end else begin
      phase      <= phaseN;
      seg        <= segN;
      bitCnt     <= cntN;
      isRead     <= isReadN;
      rspTimeout <= timeoutN;
      rspDone    <= doneN;
    end
  end

  assign cmdReady = (phase == PH_IDLE);

  // the wait loop never runs past its bound (R4)
  assert_wait_bound_R4: assert property (@(posedge clk) disable iff (!rstN)
    (seg == SEG_WAIT && phase != PH_IDLE) |-> bitCnt < WAIT_C);
endmodule

// File: rtl/xcvr_cfg_master.sv
module xcvr_cfg_master
  import xcvr_cfg_pkg::*;
#(
  parameter int PHASE_CYCLES = 8,
  parameter int WAIT_LIMIT   = 10,
  parameter int RESET_PULSES = 30
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  output logic       cmdReady,
  input  logic [1:0] cmdOp,
  input  logic [7:0] cmdAddr,
  input  logic [1:0] cmdIndex,
  input  logic [7:0] cmdWdata,
  output logic       rspDone,
  output logic [7:0] rspData,
  output logic       rspTimeout,
  output logic       cfgClk,
  output logic       cfgData,
  input  logic       cfgRdValid,
  input  logic       cfgRxData
);
  dpStrobeT          strobe;
  logic              phaseDone;
  logic [BYTE_W-1:0] cmdByte;

  assign cmdByte = cmdAddr | {5'b0, cmdIndex, 1'b0} | {7'b0, (cmdOp == 2'b00)};

  xcvr_cfg_ctrl #(
    .WAIT_LIMIT  (WAIT_LIMIT),
    .RESET_PULSES(RESET_PULSES)
  ) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cmdValid  (cmdValid),
    .cmdOp     (cmdOp),
    .phaseDone (phaseDone),
    .cfgRdValid(cfgRdValid),
    .strobe    (strobe),
    .cmdReady  (cmdReady),
    .rspDone   (rspDone),
    .rspTimeout(rspTimeout)
  );

  xcvr_cfg_dp #(
    .PHASE_CYCLES(PHASE_CYCLES)
  ) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .cmdByte  (cmdByte),
    .wrByte   (cmdWdata),
    .cfgRxData(cfgRxData),
    .phaseDone(phaseDone),
    .cfgClk   (cfgClk),
    .cfgData  (cfgData),
    .rxByte   (rspData)
  );

  assert_busy_R10: assert property (@(posedge clk) disable iff (!rstN)
    cfgClk |-> !cmdReady);
  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |=> !rspDone);
  assert_done_idle_R11: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |-> cmdReady && !cfgClk);
  assert_timeout_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    (rspDone && rspTimeout) |-> rspData == 8'h00);
  assert_idle_clk_low_R3: assert property (@(posedge clk) disable iff (!rstN)
    cmdReady |-> !cfgClk);
endmodule

// File: tb/test_xcvr_cfg_master.sv
`timescale 1ns/1ps
module test_xcvr_cfg_master;
  localparam int P = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0;
  logic [1:0] cmdOp = 2'b00;
  logic [7:0] cmdAddr = 8'h00;
  logic [1:0] cmdIndex = 2'b00;
  logic [7:0] cmdWdata = 8'h00;
  logic cfgRdValid = 1'b1;
  logic cfgRxData = 1'b0;
  logic cmdReady, rspDone, rspTimeout, cfgClk, cfgData;
  logic [7:0] rspData;

  always #2.5 clk = ~clk;

  xcvr_cfg_master #(.PHASE_CYCLES(P)) i_xcvr_cfg_master (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdOp(cmdOp), .cmdAddr(cmdAddr), .cmdIndex(cmdIndex), .cmdWdata(cmdWdata),
    .rspDone(rspDone), .rspData(rspData), .rspTimeout(rspTimeout),
    .cfgClk(cfgClk), .cfgData(cfgData), .cfgRdValid(cfgRdValid), .cfgRxData(cfgRxData)
  );

  int checks = 0;
  int failures = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor and module model
  logic bitLog [64];
  int pulseCnt = 0, respK = 0, doneCnt = 0, doneWide = 0;
  int dataAge = 0, setupBad = 0, hiRun = 0, hiBad = 0;
  logic [7:0] respByte = 8'h00, doneData = 8'h00;
  logic doneTo = 1'b0, prevClk = 1'b0, prevData = 1'b0, prevDone = 1'b0;

  always @(negedge clk) begin
    if (cfgClk && !prevClk) begin
      if (dataAge < P) setupBad++;
      if (pulseCnt < 64) bitLog[pulseCnt] = cfgData;
      pulseCnt++;
    end
    if (!cfgClk && prevClk) begin
      if (hiRun != P) hiBad++;
      hiRun = 0;
      if (respK > 0) begin
        if (pulseCnt == 8 + respK) cfgRdValid = 1'b0;
        if (pulseCnt >= 9 + respK && pulseCnt <= 16 + respK)
          cfgRxData = respByte[pulseCnt - 9 - respK];
      end
    end
    if (cfgClk) hiRun++;
    if (cfgData !== prevData) dataAge = 1; else dataAge++;
    if (rspDone) begin
      doneCnt++;
      doneData = rspData;
      doneTo = rspTimeout;
      if (prevDone) doneWide++;
    end
    prevClk = cfgClk;
    prevData = cfgData;
    prevDone = rspDone;
  end

  function automatic int expPulses(input int op, input int k);
    if (op >= 2) return 30;
    if (op == 0) return 18;
    return (k > 0) ? 20 + k : 24;
  endfunction

  function automatic logic expBit(input int op, input logic [7:0] cb,
                                  input logic [7:0] wd, input int n, input int idx);
    if (op >= 2) return 1'b0;
    if (idx < 8) return cb[idx];
    if (op == 0) return (idx < 16) ? wd[idx-8] : 1'b0;
    return (idx >= n - 3) ? 1'b0 : 1'b1;
  endfunction

  task automatic runTxn(input int op, input logic [7:0] addr, input logic [1:0] ix,
                        input logic [7:0] wd, input int k, input logic [7:0] rb);
    logic [7:0] cb, gotCmd;
    int n, bad;
    string tag;
    cb = addr | {5'b0, ix, 1'b0} | {7'b0, (op == 0)};
    tag = (op >= 2) ? "R8" : (op == 0) ? "R3" : (k > 0) ? "R4/R7" : "R6/R7";
    @(negedge clk);
    respK = (op == 1) ? k : 0;
    respByte = rb;
    cfgRdValid = 1'b1;
    cfgRxData = 1'b0;
    pulseCnt = 0; doneCnt = 0; doneWide = 0; setupBad = 0; hiBad = 0;
    cmdValid = 1'b1; cmdOp = 2'(op); cmdAddr = addr; cmdIndex = ix; cmdWdata = wd;
    @(negedge clk);
    check(cmdReady == 1'b0, "R10 ready low while busy", cmdReady, 0);
    // a competing request while busy must leave the waveform untouched (R10)
    cmdOp = (op >= 2) ? 2'b00 : 2'b10;
    cmdWdata = ~wd;
    repeat (4) @(negedge clk);
    cmdValid = 1'b0;
    while (!cmdReady) @(negedge clk);
    repeat (2) @(negedge clk);
    n = expPulses(op, k);
    check(pulseCnt == n, {tag, " pulse count"}, pulseCnt, n);
    if (op < 2) begin
      for (int i = 0; i < 8; i++) gotCmd[i] = bitLog[i];
      check(gotCmd == cb, "R1 command byte LSB first", gotCmd, cb);
    end
    bad = 0;
    if (pulseCnt == n)
      for (int i = 0; i < n; i++)
        if (bitLog[i] !== expBit(op, cb, wd, n, i)) bad++;
    check(bad == 0, {tag, " data line per pulse"}, bad, 0);
    check(cfgClk == 1'b0, {tag, " ends clock low"}, cfgClk, 0);
    check(setupBad == 0, "R2 setup before rise", setupBad, 0);
    check(hiBad == 0, "R9 high phase width", hiBad, 0);
    if (op == 1) begin
      check(doneCnt == 1 && doneWide == 0, "R11 single done pulse", doneCnt, 1);
      check(doneData == ((k > 0) ? rb : 8'h00), "R5 read data", doneData, (k > 0) ? rb : 0);
      check(doneTo == (k == 0), "R6 timeout flag", doneTo, (k == 0));
    end else begin
      check(doneCnt == 0, "R11 no done for write/reset", doneCnt, 0);
    end
  endtask

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'h1F2E3D);
    repeat (3) @(negedge clk);
    check(cmdReady == 1'b1 && cfgClk == 1'b0 && cfgData == 1'b0 && rspDone == 1'b0,
          "R12 reset state", {cmdReady, cfgClk, cfgData, rspDone}, 4'b1000);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(cmdReady == 1'b1 && cfgClk == 1'b0 && cfgData == 1'b0,
          "R12 state after reset", {cmdReady, cfgClk, cfgData}, 3'b100);
    // directed corners
    runTxn(0, 8'h40, 2'd2, 8'hA5, 0, 8'h00);
    runTxn(1, 8'h40, 2'd1, 8'h00, 1, 8'h3C);
    runTxn(1, 8'h40, 2'd3, 8'h00, 10, 8'h81);
    runTxn(1, 8'h40, 2'd0, 8'h00, 0, 8'hFF);
    runTxn(2, 8'h00, 2'd0, 8'h00, 0, 8'h00);
    runTxn(1, 8'h88, 2'd2, 8'h00, 5, 8'h00);
    runTxn(0, 8'hF8, 2'd3, 8'hFF, 0, 8'h00);
    // random mix
    for (int t = 0; t < 24; t++) begin
      int op, k;
      op = int'($urandom_range(0, 2));
      k = int'($urandom_range(0, 10));
      runTxn(op, {$urandom_range(0, 31), 3'b000}, 2'($urandom_range(0, 3)),
             8'($urandom), k, 8'($urandom));
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule